// File: doc/BRIEF.md
# AES-128 Round Key Expansion Unit

This block produces the eleven AES-128 round keys one at a time from a 128-bit cipher key. A load strobe captures the key, which is presented at once as the round-0 key. Each later next-round strobe derives the following four 32-bit words from the current four. The new first word is the previous last word rotated by one byte, byte-substituted through the S-box, then XORed with a round constant and with the previous first word. Each of the other three new words is the previous word in the same slot XORed with the new word just before it.

The byte substitution goes through a registered S-box pipeline whose depth is a parameter. While a lookup is in flight the valid flag is low. The consumer, typically an AddRoundKey stage, waits for valid, uses the key, then asks for the next one. Keys are held in the 128-bit form {w0,w1,w2,w3}, with w0 in bits 127:96.

Top module: `key_expand_unit`

## Requirements
- R1: After reset, before any load, valid_o is 0, round_o is 0 and round_key_o is 0.
- R2: One cycle after load_i is sampled high, valid_o is 1, round_o is 0 and round_key_o equals key_i as it was at the load. A load takes priority over any other activity.
- R3: A next_i pulse accepted while valid_o is 1 and round_o is below NUM_ROUNDS drives valid_o low on the following cycle. valid_o stays low for exactly SBOX_STAGES cycles and then returns to 1.
- R4: In the new key, w0' = w0 ^ SubWord(RotWord(w3)) ^ {rcon,24'h0}. RotWord moves bits 31:24 down to bits 7:0 and shifts the other bytes up by one byte. For rounds 1..10, rcon is 01,02,04,08,10,20,40,80,1B,36 in that order.
- R5: The other new words chain in order: w1' = w1 ^ w0', w2' = w2 ^ w1', w3' = w3 ^ w2'.
- R6: SubWord substitutes each byte through the AES S-box (the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, followed by the affine map with constant 63). For example S(00)=63 and S(53)=ED.
- R7: round_o increases by exactly one with each completed step, from 0 up to NUM_ROUNDS.
- R8: Once round_o equals NUM_ROUNDS, next_i has no effect: the key, index and valid flag stay as they are until the next load.
- R9: next_i is ignored while valid_o is 0, both before the first load and while a lookup is pending.
- R10: A load while a lookup is pending discards the pending result. The new key is presented as round 0 and expands correctly from there.
- R11: round_key_o does not change while valid_o is 1 unless a strobe is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Load strobe for key_i |
| key_i | input | 128 | Cipher key, w0 in bits 127:96 |
| next_i | input | 1 | Request for the next round key |
| round_key_o | output | 128 | Current round key {w0,w1,w2,w3} |
| round_o | output | 4 | Index of the current round key |
| valid_o | output | 1 | round_key_o and round_o are usable |

## Verification
The bench builds the unit with its defaults: NUM_ROUNDS of 10 and a single S-box register stage, so every step costs exactly one invalid cycle. Sixty-four loads are chosen so that the rotated last word walks through all 256 byte values. Checking the round-1 key after each of them sweeps the whole S-box through the ports against a reference built by brute-force inversion. Full eleven-key schedules for several keys, including the standard example key, cover the round constants, the index limit, ignored strobes and a load that cuts into a pending lookup.

// File: rtl/kx_pkg.sv
package kx_pkg;

   localparam int WORD_W = 32;
   localparam int BYTE_W = 8;
   localparam logic [7:0] AES_POLY_LO = 8'h1B;
   localparam logic [7:0] AFFINE_C    = 8'h63;

   typedef logic [WORD_W-1:0] word_t;
   typedef logic [BYTE_W-1:0] byte_t;

   typedef enum logic [1:0] {
      KX_EMPTY = 2'd0,
      KX_READY = 2'd1,
      KX_BUSY  = 2'd2
   } kx_state_e;

   function automatic byte_t gf_xtime(input byte_t a);
      return {a[6:0], 1'b0} ^ (a[7] ? AES_POLY_LO : 8'h00);
   endfunction

   function automatic byte_t gf_mul(input byte_t a, input byte_t b);
      byte_t acc;
      byte_t sh;
      acc = '0;
      sh  = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = gf_xtime(sh);
      end
      return acc;
   endfunction

   function automatic byte_t rotl8(input byte_t a, input int n);
      logic [15:0] d;
      d = {a, a} << n;
      return d[15:8];
   endfunction

   // inverse via x^254 (square and multiply), zero maps to zero
   function automatic byte_t sbox_calc(input byte_t x);
      byte_t res;
      byte_t base;
      logic [7:0] ex;
      res  = 8'h01;
      base = x;
      ex   = 8'd254;
      for (int i = 0; i < 8; i++) begin
         if (ex[i]) res = gf_mul(res, base);
         base = gf_mul(base, base);
      end
      return res ^ rotl8(res, 1) ^ rotl8(res, 2) ^ rotl8(res, 3)
                 ^ rotl8(res, 4) ^ AFFINE_C;
   endfunction

   // constant for step r (r >= 1): 01 doubled r-1 times in GF(2^8)
   function automatic byte_t rcon_calc(input int r);
      byte_t v;
      v = 8'h01;
      for (int i = 2; i <= 16; i++) begin
         if (i <= r) v = gf_xtime(v);
      end
      return v;
   endfunction

   function automatic word_t rot_word(input word_t w);
      return {w[23:0], w[31:24]};
   endfunction

endpackage

// File: rtl/kx_sbox_pipe.sv
module kx_sbox_pipe
   import kx_pkg::*;
#(
   parameter int STAGES = 1
) (
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  start_i,
   input  logic  flush_i,
   input  word_t word_i,
   output word_t word_o,
   output logic  vld_o
);

   localparam int LANES = WORD_W / BYTE_W;

   if (STAGES < 1 || STAGES > 4) begin : g_bad_stages
      $error("kx_sbox_pipe: STAGES must be 1..4");
   end

   word_t lut_w;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lut_w[l*BYTE_W +: BYTE_W] = sbox_calc(word_i[l*BYTE_W +: BYTE_W]);
   end

   if (STAGES == 1) begin : g_single
      word_t d_q;
      logic  v_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            d_q <= '0;
            v_q <= 1'b0;
         end else begin
            d_q <= lut_w;
            v_q <= start_i && !flush_i;
         end
      end
      assign word_o = d_q;
      assign vld_o  = v_q;
   end else begin : g_multi
      word_t             d_q [STAGES];
      logic [STAGES-1:0] v_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) d_q[i] <= '0;
            v_q <= '0;
         end else begin
            d_q[0] <= lut_w;
            for (int i = 1; i < STAGES; i++) d_q[i] <= d_q[i-1];
            if (flush_i) v_q <= '0;
            else         v_q <= {v_q[STAGES-2:0], start_i};
         end
      end
      assign word_o = d_q[STAGES-1];
      assign vld_o  = v_q[STAGES-1];

      // at most one lookup in flight at any time
      AST_ONE_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $onehot0(v_q)); // R3
   end

endmodule

// File: rtl/kx_round_step.sv
module kx_round_step
   import kx_pkg::*;
#(
   parameter int NWORDS = 4
) (
   input  logic [NWORDS*WORD_W-1:0] prev_i,
   input  word_t                    sub_i,
   input  byte_t                    rcon_i,
   output logic [NWORDS*WORD_W-1:0] next_o
);

   localparam int TOP = NWORDS*WORD_W;

   if (NWORDS < 2) begin : g_bad_words
      $error("kx_round_step: NWORDS must be at least 2");
   end

   word_t nw [NWORDS];

   assign nw[0] = prev_i[TOP-1 -: WORD_W] ^ sub_i ^ {rcon_i, {(WORD_W-BYTE_W){1'b0}}};

   for (genvar i = 1; i < NWORDS; i++) begin : g_chain
      assign nw[i] = prev_i[TOP-1-i*WORD_W -: WORD_W] ^ nw[i-1];
   end

   for (genvar i = 0; i < NWORDS; i++) begin : g_pack
      assign next_o[TOP-1-i*WORD_W -: WORD_W] = nw[i];
   end

endmodule

// File: rtl/key_expand_unit.sv
module key_expand_unit
   import kx_pkg::*;
#(
   parameter int KEY_W       = 128,
   parameter int NUM_ROUNDS  = 10,
   parameter int SBOX_STAGES = 1
) (
   input  logic                                 clk_i,
   input  logic                                 rst_ni,
   input  logic                                 load_i,
   input  logic [KEY_W-1:0]                     key_i,
   input  logic                                 next_i,
   output logic [KEY_W-1:0]                     round_key_o,
   output logic [$clog2(NUM_ROUNDS+1)-1:0]      round_o,
   output logic                                 valid_o
);

   localparam int NWORDS = KEY_W / WORD_W;
   localparam int RND_W  = $clog2(NUM_ROUNDS+1);
   localparam logic [RND_W-1:0] LAST_RND = RND_W'(NUM_ROUNDS);

   if (KEY_W != 128) begin : g_bad_key
      $error("key_expand_unit: only 128-bit keys are supported");
   end
   if (NUM_ROUNDS < 1 || NUM_ROUNDS > 10) begin : g_bad_rounds
      $error("key_expand_unit: NUM_ROUNDS must be 1..10");
   end

   kx_state_e        state_q;
   logic [KEY_W-1:0] words_q;
   logic [RND_W-1:0] rnd_q;
   logic [KEY_W-1:0] next_words;
   word_t            sub_w;
   logic             sub_vld;
   logic             accept;
   byte_t            rcon_b;

   assign accept = (state_q == KX_READY) && next_i && (rnd_q != LAST_RND) && !load_i;
   assign rcon_b = rcon_calc(int'(rnd_q) + 1);

   kx_sbox_pipe #(.STAGES(SBOX_STAGES)) u_sbox (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (accept),
      .flush_i (load_i),
      .word_i  (rot_word(words_q[WORD_W-1:0])),
      .word_o  (sub_w),
      .vld_o   (sub_vld)
   );

   kx_round_step #(.NWORDS(NWORDS)) u_step (
      .prev_i (words_q),
      .sub_i  (sub_w),
      .rcon_i (rcon_b),
      .next_o (next_words)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= KX_EMPTY;
         words_q <= '0;
         rnd_q   <= '0;
      end else if (load_i) begin
         state_q <= KX_READY;
         words_q <= key_i;
         rnd_q   <= '0;
      end else begin
         unique case (state_q)
            KX_READY: if (accept) state_q <= KX_BUSY;
            KX_BUSY:  if (sub_vld) begin
               words_q <= next_words;
               rnd_q   <= rnd_q + 1'b1;
               state_q <= KX_READY;
            end
            default:  state_q <= KX_EMPTY;
         endcase
      end
   end

   assign round_key_o = words_q;
   assign round_o     = rnd_q;
   assign valid_o     = (state_q == KX_READY);

   AST_LOAD_ROUND0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (valid_o && round_o == '0)); // R2
   AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && next_i && !load_i && round_o != LAST_RND) |=> !valid_o); // R3
   AST_IDX_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      round_o <= LAST_RND); // R7
   AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(valid_o) && !$past(load_i)) |-> (round_o == RND_W'($past(round_o) + 1'b1))); // R7
   AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && round_o == LAST_RND && !load_i) |=> (valid_o && $stable(round_key_o))); // R8
   AST_IDLE_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!valid_o && state_q == KX_EMPTY && !load_i) |=> !valid_o); // R9
   AST_KEY_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && !load_i) |=> $stable(round_key_o)); // R11

endmodule

// File: tb/tb_key_expand_unit.sv
module tb_key_expand_unit;

   localparam int NR = 10;
   localparam int ST = 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         load = 1'b0;
   logic [127:0] key = '0;
   logic         nxt = 1'b0;
   logic [127:0] rk;
   logic [3:0]   rnd;
   logic         vld;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   logic [7:0] sb_tab [256];
   logic [7:0] rc_tab [10] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10,
                               8'h20, 8'h40, 8'h80, 8'h1B, 8'h36};

   always #2 clk = ~clk;

   key_expand_unit #(.KEY_W(128), .NUM_ROUNDS(NR), .SBOX_STAGES(ST)) dut (
      .clk_i(clk), .rst_ni(rst_n), .load_i(load), .key_i(key), .next_i(nxt),
      .round_key_o(rk), .round_o(rnd), .valid_o(vld));

   function automatic logic [7:0] tb_mul(input logic [7:0] a, input logic [7:0] b);
      logic [15:0] p;
      p = '0;
      for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
      for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011B << (i - 8));
      return p[7:0];
   endfunction

   function automatic logic [127:0] tb_next(input logic [127:0] k, input int r);
      logic [31:0] w0, w1, w2, w3, t;
      w0 = k[127:96]; w1 = k[95:64]; w2 = k[63:32]; w3 = k[31:0];
      t = {sb_tab[w3[23:16]], sb_tab[w3[15:8]], sb_tab[w3[7:0]], sb_tab[w3[31:24]]};
      t = t ^ {rc_tab[r-1], 24'h0};
      w0 = w0 ^ t; w1 = w1 ^ w0; w2 = w2 ^ w1; w3 = w3 ^ w2;
      return {w0, w1, w2, w3};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_load(input logic [127:0] k, input string req);
      load = 1'b1; key = k;
      @(negedge clk);
      load = 1'b0;
      chk(vld === 1'b1 && rnd === 4'd0, req, "valid/index after load", {rnd, 3'b0, vld}, {4'd0, 3'b0, 1'b1});
      chk(rk === k, req, "round 0 key", rk, k);
   endtask

   // one step: pulse next, watch the invalid window, return on valid
   task automatic do_step(input string req);
      int cnt;
      nxt = 1'b1;
      @(negedge clk);
      nxt = 1'b0;
      chk(vld === 1'b0, "R3", "valid low after accepted next", {127'b0, vld}, 128'd0);
      cnt = 1;
      while (vld !== 1'b1 && cnt < 20) begin
         @(negedge clk);
         if (vld !== 1'b1) cnt++;
      end
      chk(cnt == ST, "R3", {req, " invalid window length"}, 128'(cnt), 128'(ST));
   endtask

   task automatic full_sched(input logic [127:0] k);
      logic [127:0] e;
      e = k;
      do_load(k, "R2");
      for (int r = 1; r <= NR; r++) begin
         do_step("R3");
         e = tb_next(e, r);
         chk(rk === e, r == 1 ? "R4" : "R5", $sformatf("round %0d key", r), rk, e);
         chk(rnd === 4'(r), "R7", "round index", 128'(rnd), 128'(r));
      end
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [127:0] e, hold;
      logic [7:0] inv, b;
      for (int x = 0; x < 256; x++) begin
         inv = 8'h00;
         for (int y = 1; y < 256; y++) if (tb_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
         for (int i = 0; i < 8; i++)
            b[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
         sb_tab[x] = b ^ 8'h63;
      end

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(vld === 1'b0 && rnd === 4'd0, "R1", "valid/index after reset", {rnd, 3'b0, vld}, 128'd0);
      chk(rk === 128'd0, "R1", "key after reset", rk, 128'd0);

      // R9 next before any load
      nxt = 1'b1; @(negedge clk); nxt = 1'b0;
      repeat (3) @(negedge clk);
      chk(vld === 1'b0 && rnd === 4'd0, "R9", "next before load ignored", {rnd, 3'b0, vld}, 128'd0);

      // R6 reference table sanity
      chk(sb_tab[8'h00] == 8'h63 && sb_tab[8'h53] == 8'hED, "R6", "reference S-box points",
          {sb_tab[8'h00], sb_tab[8'h53]}, 128'h63ED);

      // standard key, full schedule and known last key
      full_sched(128'h2b7e151628aed2a6abf7158809cf4f3c);
      chk(rk === 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R6", "known round 10 key",
          rk, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);

      // R8 next after last round
      hold = rk;
      nxt = 1'b1; repeat (2) @(negedge clk); nxt = 1'b0;
      repeat (3) @(negedge clk);
      chk(vld === 1'b1 && rnd === 4'd10, "R8", "index/valid held after last round", {rnd, 3'b0, vld}, {4'd10, 3'b0, 1'b1});
      chk(rk === hold, "R8", "key held after last round", rk, hold);

      full_sched(128'd0);
      full_sched({128{1'b1}});

      // R11 stability with no strobe
      e = 128'h000102030405060708090a0b0c0d0e0f;
      do_load(e, "R2");
      repeat (5) @(negedge clk);
      chk(rk === e && vld === 1'b1, "R11", "key stable while idle", rk, e);

      // R9 next held during pending lookup counts once
      nxt = 1'b1; repeat (2) @(negedge clk); nxt = 1'b0;
      repeat (4) @(negedge clk);
      e = tb_next(e, 1);
      chk(rnd === 4'd1, "R9", "next during lookup ignored (index)", 128'(rnd), 128'd1);
      chk(rk === e, "R9", "next during lookup ignored (key)", rk, e);

      // R10 load while a lookup is pending
      nxt = 1'b1; @(negedge clk); nxt = 1'b0;
      e = 128'hfedcba98765432100123456789abcdef;
      do_load(e, "R10");
      repeat (3) @(negedge clk);
      chk(rk === e && rnd === 4'd0, "R10", "stale result discarded", rk, e);
      do_step("R10");
      e = tb_next(e, 1);
      chk(rk === e && rnd === 4'd1, "R10", "expansion after reload", rk, e);

      // R6 exhaustive S-box sweep through round 1
      for (int i = 0; i < 64; i++) begin
         logic [127:0] k;
         logic [7:0] a;
         a = 8'(4 * i);
         k = {32'(i) * 32'h9E3779B9, 32'(i) ^ 32'hA5A5_0F0F, 32'(i) * 32'h0101_0101,
              a + 8'd3, a, a + 8'd1, a + 8'd2};
         do_load(k, "R2");
         do_step("R6");
         e = tb_next(k, 1);
         chk(rk === e, "R6", $sformatf("S-box sweep bytes %02h..%02h", a, a + 8'd3), rk, e);
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule